// File: doc/BRIEF.md
# Non-Stoppable Watchdog Timer

This block is a watchdog countdown timer whose timeout is fixed when the design is built. Software reaches it through a small synchronous register bus with a request strobe, a write enable, a word address and write data. After reset the watchdog is idle. Software arms it by writing the arm bit in the control word, and from then on no register write can halt it.

While armed, the counter counts down once per clock cycle. Software keeps the system alive by writing to the kick address. The data of that write is ignored, and the write reloads the counter with the fixed timeout. If the counter reaches zero, the block raises its reset-request output for a single cycle. The counter then reloads and keeps counting, so a system reset that does not reach this block still leaves it supervising.

Top module: `wdt_top`

## Requirements
- R1: After reset the watchdog is idle. The status run bit reads 0 and `rst_req_o` stays low for any length of time until the watchdog is armed.
- R2: A write to the control address (1) with data bit 0 set arms the watchdog. A control write with bit 0 clear does not arm it.
- R3: Once armed, the watchdog cannot be disarmed. Control writes of any value, including the halt bit (bit 1) and repeated arm writes, do not clear the run bit and do not change the timing of the next expiry.
- R4: A write to the kick address (2), whatever its data, reloads the counter with TIMEOUT. Without another kick, the next reset request appears TIMEOUT+1 cycles after the edge that captured the kick.
- R5: Without a kick, the first reset request appears TIMEOUT+1 cycles after the edge that captured the arm write.
- R6: `rst_req_o` is high for exactly one cycle per expiry. The counter reloads on its own, and the next request follows TIMEOUT+1 cycles later.
- R7: A read of the status address (0) returns the run bit in bit 0 and zeros in all other bits. `rdata_o` is registered and is valid in the cycle after the read request.
- R8: Kick writes made before arming are accepted but do not start the countdown. No reset request follows them.
- R9: A kick captured on the same edge that detects a zero count does not cancel the expiry. The request is still issued, and the next one follows TIMEOUT+1 cycles later. A kick captured one edge earlier prevents the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable (1 = write, 0 = read) |
| addr_i | input | 2 | Word address: 0 status, 1 control, 2 kick |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| rst_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
Two events can fall in the same cycle: a software kick, and the internal detection of a zero count. The bench provokes this by arming the watchdog and then counting edges, so that the kick write is captured exactly on the edge where the count is zero. It then judges that the reset request is still raised in that cycle and that the following request comes a full TIMEOUT+1 cycles later. A kick captured one edge earlier is checked as well: it must suppress the request entirely, and the next request must come TIMEOUT+1 cycles after that kick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS = 2'd0,
    REG_CTRL   = 2'd1,
    REG_KICK   = 2'd2
  } wdt_reg_e;

  localparam int CTRL_ARM_BIT  = 0;
  localparam int CTRL_HALT_BIT = 1;
  localparam int STAT_RUN_BIT  = 0;
endpackage

// File: rtl/wdt_regif.sv
module wdt_regif
  import wdt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              run_o,
  output logic              kick_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic wr_ctrl, rd_status, arm_req, halt_req;
  logic unused_halt;

  assign wr_ctrl   = req_i && we_i && (addr_i == REG_CTRL);
  assign kick_o    = req_i && we_i && (addr_i == REG_KICK);
  assign rd_status = req_i && !we_i && (addr_i == REG_STATUS);
  assign arm_req   = wr_ctrl && wdata_i[CTRL_ARM_BIT];
  // halt is decoded but has no effect by design
  assign halt_req  = wr_ctrl && wdata_i[CTRL_HALT_BIT];
  assign unused_halt = halt_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_o <= 1'b0;
    else if (arm_req) run_o <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else begin
      rdata_o <= '0;
      if (rd_status) rdata_o[STAT_RUN_BIT] <= run_o;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int TIMEOUT = 20,
  localparam int CNT_W  = $clog2(TIMEOUT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             kick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TIMEOUT);

  logic at_zero;
  assign at_zero = (cnt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o    <= RELOAD;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (run_i && at_zero) begin
        // expiry wins over a kick in the same cycle
        expire_o <= 1'b1;
        cnt_o    <= RELOAD;
      end else if (kick_i) begin
        cnt_o <= RELOAD;
      end else if (run_i) begin
        cnt_o <= cnt_o - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int TIMEOUT = 20,
  parameter int DATA_W  = 16,
  localparam int CNT_W  = $clog2(TIMEOUT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o
);
  logic             run;
  logic             kick;
  logic [CNT_W-1:0] cnt;

  wdt_regif #(.DATA_W(DATA_W)) u_regif (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .run_o   (run),
    .kick_o  (kick),
    .rdata_o (rdata_o)
  );

  wdt_counter #(.TIMEOUT(TIMEOUT)) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .kick_i   (kick),
    .cnt_o    (cnt),
    .expire_o (rst_req_o)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int TIMEOUT = 20,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rst_req_o,
  input logic              run,
  input logic              kick,
  input logic [CNT_W-1:0]  cnt
);
  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !rst_req_o); // R1
  AST_RUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |=> run); // R3
  AST_KICK_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick |=> (cnt == CNT_W'(TIMEOUT))); // R4
  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !kick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R5
  AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R6
  AST_STATUS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == REG_STATUS) |=> (rdata_o == DATA_W'($past(run)))); // R7
  AST_ZERO_EXPIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && cnt == '0) |=> rst_req_o); // R9
endmodule

bind wdt_top wdt_checker #(
  .TIMEOUT(TIMEOUT), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_wdt_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .rst_req_o (rst_req_o),
  .run       (run),
  .kick      (kick),
  .cnt       (cnt)
);

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
  localparam int CLK_PERIOD = 10;
  localparam int TB_T       = 20;
  localparam int DW         = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic          we_i = 1'b0;
  logic [1:0]    addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          rst_req_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wdt_top #(.TIMEOUT(TB_T), .DATA_W(DW)) dut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .rst_req_o
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; req_i = 1'b0; we_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    d = rdata_o;
    req_i = 1'b0;
  endtask

  // pulse expected after the n-th edge from now, low before and after it
  task automatic expect_pulse(input int n, input string tag);
    for (int i = 1; i < n; i++) begin
      @(negedge clk_i);
      chk({tag, " early"}, DW'(rst_req_o), '0);
    end
    @(negedge clk_i);
    chk({tag, " pulse"}, DW'(rst_req_o), 1);
    @(negedge clk_i);
    chk({tag, " width"}, DW'(rst_req_o), '0);
  endtask

  task automatic t_reset_idle();
    logic [DW-1:0] d;
    do_reset();
    chk("R1 rst_req after reset", DW'(rst_req_o), '0);
    rd(2'd0, d);
    chk("R1 run after reset", d, '0);
    wr(2'd2, 16'hFFFF);
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'h0002);
    wr(2'd1, 16'h0000);
    for (int i = 0; i < 3 * TB_T; i++) begin
      @(negedge clk_i);
      chk("R8 no request while idle", DW'(rst_req_o), '0);
    end
    rd(2'd0, d);
    chk("R2 arm bit clear keeps idle", d, '0);
  endtask

  task automatic t_arm_expire();
    logic [DW-1:0] d;
    do_reset();
    wr(2'd1, 16'h0001);
    expect_pulse(TB_T + 1, "R5 first expiry");
    expect_pulse(TB_T, "R6 auto reload");
    rd(2'd0, d);
    chk("R7 status run", d, 16'h0001);
    rd(2'd1, d);
    chk("R7 non-status read zero", d, '0);
  endtask

  task automatic t_stop_ignored();
    logic [DW-1:0] d;
    do_reset();
    wr(2'd1, 16'h0001);
    wr(2'd1, 16'h0002);
    wr(2'd1, 16'h0000);
    wr(2'd1, 16'hFFFF);
    expect_pulse(TB_T - 2, "R3 expiry timing unchanged");
    rd(2'd0, d);
    chk("R3 run still set", d, 16'h0001);
  endtask

  task automatic t_kick();
    do_reset();
    wr(2'd1, 16'h0001);
    repeat (5) @(negedge clk_i);
    wr(2'd2, 16'h1234);
    expect_pulse(TB_T + 1, "R4 kick reload");
    repeat (3) @(negedge clk_i);
    wr(2'd2, 16'h0000);
    expect_pulse(TB_T + 1, "R4 kick zero data");
  endtask

  task automatic t_kick_race();
    do_reset();
    wr(2'd1, 16'h0001);
    repeat (TB_T) @(negedge clk_i);
    wr(2'd2, 16'h0001);
    chk("R9 same-edge kick still expires", DW'(rst_req_o), 1);
    expect_pulse(TB_T + 1, "R9 next after race");
    do_reset();
    wr(2'd1, 16'h0001);
    repeat (TB_T - 1) @(negedge clk_i);
    wr(2'd2, 16'h0001);
    expect_pulse(TB_T + 1, "R9 kick one edge early saves");
  endtask

  initial begin
    t_reset_idle();
    t_arm_expire();
    t_stop_ignored();
    t_kick();
    t_kick_race();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule